// File: doc/BRIEF.md
# Eight-Bit Arithmetic Unit with Status Flags

This block is the execute stage of a small eight-bit core. It takes a destination operand, a source operand, an eight-bit immediate and a three-bit operation code, and it returns the result to the register file with a write strobe. Alongside the result it keeps a six-bit status register. The status register holds carry, zero, negative, signed overflow, sign and half-carry. Each operation has its own rule for which flags it updates and which it leaves alone.

Add, subtract, the two compares, move and load-immediate are accepted in one cycle. Their result and write strobe appear after the next rising edge. An unsigned eight-by-eight multiply takes two cycles. It holds a busy output through its first cycle, then returns a sixteen-bit product on two result bytes with two write strobes. While busy is high, the block ignores a new request. The caller does the decoding: it selects which register values feed the operand inputs and where the written bytes go.

Top module: `alu8_status`

## Requirements
- R1: After synchronous reset, the status register is 0, and res_lo, res_hi, wr_lo, wr_hi and busy are all 0.
- R2: Operation codes are ADD=0, SUB=1, CMP=2, CMPI=3, MOV=4, LDI=5, MUL=6, and 7 does nothing. The status bits are laid out as flags[0]=C, [1]=Z, [2]=N, [3]=V, [4]=S, [5]=H. A request is accepted at a rising edge when op_valid=1 and busy=0. For ADD, res_lo = (dst+src) mod 256, wr_lo=1 after that same edge, and C is the carry out of bit 7.
- R3: For ADD, H is the carry out of bit 3. For SUB, CMP and CMPI, H is the borrow into bit 4, meaning the low nibble of the destination is below the low nibble of the subtrahend.
- R4: For ADD, SUB, CMP and CMPI, N is bit 7 of the result and S = N xor V. For ADD, V is set when both operands have the same sign and the result's sign differs from it. For subtraction, V is set when the operand signs differ and the result's sign differs from the destination's sign.
- R5: For SUB, res_lo = (dst-src) mod 256 with wr_lo=1, and C is set exactly when dst < src as unsigned numbers.
- R6: CMP computes dst-src and CMPI computes dst-imm. Both update C, Z, N, V, S and H exactly as SUB would, and neither one raises wr_lo.
- R7: MOV writes src and LDI writes imm to res_lo with wr_lo=1. Neither changes any status bit.
- R8: MUL raises busy for the one cycle after it is accepted, with wr_lo=0 in that cycle. In the next cycle, {res_hi,res_lo} = dst*src, wr_lo=wr_hi=1 and busy=0.
- R9: MUL sets C to bit 15 of the product and Z to whether the whole product is zero. It leaves N, V, S and H unchanged.
- R10: A request presented while busy=1 is dropped. It writes nothing and changes no flag.
- R11: For ADD, SUB, CMP and CMPI, Z is set exactly when the eight-bit result is zero.
- R12: Opcode 7 writes nothing and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code |
| dst_val | input | 8 | Destination operand |
| src_val | input | 8 | Source operand |
| imm_val | input | 8 | Immediate operand |
| res_lo | output | 8 | Result, or low product byte |
| res_hi | output | 8 | High product byte (0 otherwise) |
| wr_lo | output | 1 | Write strobe for res_lo |
| wr_hi | output | 1 | Write strobe for res_hi |
| busy | output | 1 | Multiply in its first cycle |
| flags | output | 6 | Status register {H,S,V,N,Z,C} |

## Verification
Single-cycle operations are due one edge after acceptance. The bench drives each request on a falling edge, waits for exactly one rising edge and then samples the result, the strobes and the flags a nanosecond later. A multiply is sampled twice: once after its accepting edge, when only busy must be high, and once after the following edge, when the product, both strobes and the new C and Z must be present. Ignored and flag-preserving cases are checked in the cycle right after the stimulus, through the strobes and the flags output.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW = 8;
    localparam int NFLAG = 6;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_CMPI = 3'd3,
        OP_MOV  = 3'd4,
        OP_LDI  = 3'd5,
        OP_MUL  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    // bit 0 = c ... bit 5 = h
    typedef struct packed {
        logic h;
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } stat_t;

    localparam stat_t MASK_ARITH = '{h:1'b1, s:1'b1, v:1'b1, n:1'b1, z:1'b1, c:1'b1};
    localparam stat_t MASK_MUL   = '{h:1'b0, s:1'b0, v:1'b0, n:1'b0, z:1'b1, c:1'b1};
    localparam stat_t MASK_NONE  = '0;

    function automatic logic op_writes(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MOV) || (op == OP_LDI);
    endfunction

    function automatic logic op_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP) || (op == OP_CMPI);
    endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] r,
    output stat_t        f
);
    localparam int HB = 4;

    logic [W:0]  full;
    logic [HB:0] half;

    always_comb begin
        if (sub) begin
            full = {1'b0, a} - {1'b0, b};
            half = {1'b0, a[HB-1:0]} - {1'b0, b[HB-1:0]};
        end else begin
            full = {1'b0, a} + {1'b0, b};
            half = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]};
        end
        r   = full[W-1:0];
        f.c = full[W];
        f.h = half[HB];
        f.n = full[W-1];
        f.z = (full[W-1:0] == '0);
        if (sub)
            f.v = (a[W-1] != b[W-1]) && (full[W-1] != a[W-1]);
        else
            f.v = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
        f.s = f.n ^ f.v;
    end
endmodule

// File: rtl/alu8_mul2.sv
module alu8_mul2
    import alu8_pkg::*;
#(
    parameter int W = DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] prod_nxt,
    output logic [2*W-1:0] prod_q
);
    logic [W-1:0] a_q, b_q;

    assign prod_nxt = {{W{1'b0}}, a_q} * {{W{1'b0}}, b_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            prod_q <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                prod_q <= prod_nxt;
                done   <= 1'b1;
                busy   <= 1'b0;
            end else if (start) begin
                a_q  <= a;
                b_q  <= b;
                busy <= 1'b1;
            end
        end
    end

    AST_MUL_ONE_BUSY_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy && done)); // R8
endmodule

// File: rtl/alu8_statreg.sv
module alu8_statreg
    import alu8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  stat_t en,
    input  stat_t nxt,
    output stat_t q
);
    logic [NFLAG-1:0] en_v, nxt_v, q_v;

    assign en_v  = en;
    assign nxt_v = nxt;
    assign q     = q_v;

    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)        q_v[i] <= 1'b0;
            else if (en_v[i]) q_v[i] <= nxt_v[i];
        end
    end

    AST_SIGN_IS_N_XOR_V: assert property (@(posedge clk) disable iff (rst)
        q.s == (q.n ^ q.v)); // R4
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [2:0]  op_sel,
    input  logic [7:0]  dst_val,
    input  logic [7:0]  src_val,
    input  logic [7:0]  imm_val,
    output logic [7:0]  res_lo,
    output logic [7:0]  res_hi,
    output logic        wr_lo,
    output logic        wr_hi,
    output logic        busy,
    output logic [5:0]  flags
);
    alu_op_e    op;
    logic       acc;
    logic [DW-1:0] sub_rhs, as_r, one_res;
    stat_t      as_f, st_en, st_nxt, st_q;
    logic [DW-1:0] res_q;
    logic       wr_q;
    logic       mul_done;
    logic [2*DW-1:0] p_nxt, p_q;

    assign op  = alu_op_e'(op_sel);
    assign acc = op_valid && !busy;

    assign sub_rhs = (op == OP_CMPI) ? imm_val : src_val;

    alu8_addsub #(.W(DW)) u_as (
        .a   (dst_val),
        .b   (sub_rhs),
        .sub (op != OP_ADD),
        .r   (as_r),
        .f   (as_f)
    );

    alu8_mul2 #(.W(DW)) u_mul (
        .clk      (clk),
        .rst      (rst),
        .start    (acc && (op == OP_MUL)),
        .a        (dst_val),
        .b        (src_val),
        .busy     (busy),
        .done     (mul_done),
        .prod_nxt (p_nxt),
        .prod_q   (p_q)
    );

    always_comb begin
        case (op)
            OP_MOV:  one_res = src_val;
            OP_LDI:  one_res = imm_val;
            default: one_res = as_r;
        endcase
    end

    always_comb begin
        st_en  = MASK_NONE;
        st_nxt = as_f;
        if (busy) begin
            st_en    = MASK_MUL;
            st_nxt   = '0;
            st_nxt.c = p_nxt[2*DW-1];
            st_nxt.z = (p_nxt == '0);
        end else if (acc && op_arith(op)) begin
            st_en = MASK_ARITH;
        end
    end

    alu8_statreg u_st (
        .clk (clk),
        .rst (rst),
        .en  (st_en),
        .nxt (st_nxt),
        .q   (st_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            wr_q <= acc && op_writes(op);
            if (acc && op_writes(op))
                res_q <= one_res;
        end
    end

    assign res_lo = mul_done ? p_q[DW-1:0] : res_q;
    assign res_hi = mul_done ? p_q[2*DW-1:DW] : '0;
    assign wr_lo  = wr_q | mul_done;
    assign wr_hi  = mul_done;
    assign flags  = st_q;

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc && (op == OP_CMP || op == OP_CMPI)) |=> !wr_lo); // R6
    AST_MOVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (acc && (op == OP_MOV || op == OP_LDI)) |=> $stable(flags)); // R7
    AST_HI_WITH_LO: assert property (@(posedge clk) disable iff (rst)
        wr_hi |-> wr_lo); // R8
    AST_MUL_CARRY_BIT15: assert property (@(posedge clk) disable iff (rst)
        wr_hi |-> (flags[0] == res_hi[7])); // R9
    AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        busy |=> !wr_q); // R10
endmodule

// File: tb/sim_alu8_status.sv
module sim_alu8_status;
    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [2:0] op_sel;
    logic [7:0] dst_val, src_val, imm_val;
    logic [7:0] res_lo, res_hi;
    logic       wr_lo, wr_hi, busy;
    logic [5:0] flags;

    int n_chk = 0;
    int n_bad = 0;
    logic [5:0] ef; // expected flags {H,S,V,N,Z,C}

    always #2 clk = ~clk;

    alu8_status u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
        .res_lo(res_lo), .res_hi(res_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .busy(busy), .flags(flags)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference flags for add/sub from the requirements
    function automatic logic [5:0] ref_flags(logic sub, logic [7:0] a, logic [7:0] b);
        int ia = a, ib = b;
        int r  = sub ? ia - ib : ia + ib;
        int hl = sub ? (ia % 16) - (ib % 16) : (ia % 16) + (ib % 16);
        logic [7:0] r8 = r[7:0];
        logic c = sub ? (ia < ib) : (r > 255);
        logic h = sub ? (hl < 0) : (hl > 15);
        logic v = sub ? ((a[7] != b[7]) && (r8[7] != a[7]))
                      : ((a[7] == b[7]) && (r8[7] != a[7]));
        logic n = r8[7];
        return {h, n ^ v, v, n, (r8 == 8'h00), c};
    endfunction

    task automatic issue(logic [2:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] k);
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; dst_val = a; src_val = b; imm_val = k;
        @(posedge clk); #1;
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 flags", flags, 0);
        chk("R1 res_lo", res_lo, 0);
        chk("R1 res_hi", res_hi, 0);
        chk("R1 strobes", {wr_hi, wr_lo, busy}, 0);
        ef = 0;
    endtask

    task automatic t_arith(string tag, logic [2:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] k);
        logic sub = (op != 3'd0);
        logic [7:0] rhs = (op == 3'd3) ? k : b;
        logic [7:0] r = sub ? a - rhs : a + rhs;
        logic wr = (op == 3'd0 || op == 3'd1);
        issue(op, a, b, k);
        ef = ref_flags(sub, a, rhs);
        chk({tag, " flags"}, flags, ef);
        chk({tag, " wr_lo"}, wr_lo, wr);
        if (wr) chk({tag, " res"}, res_lo, r);
    endtask

    task automatic t_move(string tag, logic [2:0] op, logic [7:0] b, logic [7:0] k);
        issue(op, 8'h5a, b, k);
        chk({tag, " wr_lo"}, wr_lo, 1);
        chk({tag, " res"}, res_lo, (op == 3'd4) ? b : k);
        chk({tag, " flags kept"}, flags, ef);
    endtask

    task automatic t_mul(string tag, logic [7:0] a, logic [7:0] b, logic intrude);
        logic [15:0] p = a * b;
        issue(3'd6, a, b, 8'h00);
        chk("R8 busy first cycle", busy, 1);
        chk("R8 no write first cycle", {wr_hi, wr_lo}, 0);
        if (intrude) begin
            @(negedge clk);
            op_valid = 1'b1; op_sel = 3'd0; dst_val = 8'h7f; src_val = 8'h01;
            @(posedge clk); #1;
            op_valid = 1'b0;
        end else begin
            @(posedge clk); #1;
        end
        ef[0] = p[15];
        ef[1] = (p == 16'h0);
        chk({tag, " R8 product"}, {res_hi, res_lo}, p);
        chk({tag, " R8 strobes"}, {wr_hi, wr_lo, busy}, 3'b110);
        chk({tag, " R9 flags"}, flags, ef);
        if (intrude) begin
            @(posedge clk); #1;
            chk("R10 dropped write", wr_lo, 0);
            chk("R10 dropped flags", flags, ef);
        end
    endtask

    task automatic t_noop;
        issue(3'd7, 8'h12, 8'h34, 8'h56);
        chk("R12 no write", {wr_hi, wr_lo}, 0);
        chk("R12 flags kept", flags, ef);
    endtask

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_sel = 0; dst_val = 0; src_val = 0; imm_val = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_arith("R2 add plain", 3'd0, 8'h12, 8'h34, 8'h00);
        t_arith("R2 add carry R11 zero", 3'd0, 8'hff, 8'h01, 8'h00);
        t_arith("R3 add half", 3'd0, 8'h0f, 8'h01, 8'h00);
        t_arith("R4 add overflow", 3'd0, 8'h7f, 8'h01, 8'h00);
        t_arith("R4 add neg overflow", 3'd0, 8'h80, 8'h80, 8'h00);
        t_move("R7 mov", 3'd4, 8'h99, 8'h00);
        t_move("R7 ldi", 3'd5, 8'h00, 8'hc3);
        t_arith("R5 sub borrow", 3'd1, 8'h10, 8'h20, 8'h00);
        t_arith("R5 sub plain", 3'd1, 8'h50, 8'h30, 8'h00);
        t_arith("R3 sub half", 3'd1, 8'h30, 8'h01, 8'h00);
        t_arith("R4 sub overflow", 3'd1, 8'h80, 8'h01, 8'h00);
        t_arith("R6 cmp equal R11", 3'd2, 8'h44, 8'h44, 8'h00);
        t_arith("R6 cmpi", 3'd3, 8'h05, 8'hff, 8'h09);
        t_mul("basic", 8'h0c, 8'h0b, 1'b0);
        t_mul("top bit", 8'hff, 8'hff, 1'b0);
        t_mul("zero", 8'h00, 8'h37, 1'b1);
        t_noop();
        for (int i = 0; i < 8; i++)
            t_arith("R4 sweep", 3'(i % 4), 8'(i * 37 + 11), 8'(i * 91 + 5), 8'(i * 13));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #40000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule